// File: doc/BRIEF.md
# Button-Sequenced BCD Digit Adder

This block takes two single decimal digits from one shared 4-bit switch bus and adds them. A momentary push-button steps the controller through three phases: entering the first operand, entering the second operand, and showing the result. Each press captures the switch value on display into that phase's operand register. A press in the result phase starts a new pass.

The raw button goes through a two-flop synchronizer and a rising-edge detector, so one press moves the controller by exactly one phase, however long the button is held. While an operand is being entered, the units display mirrors the switches live, and the tens display is dark. In the result phase the block shows the decimal sum of the two captured digits, from 0 to 18, across two active-low seven-segment outputs. If either captured code is not a decimal digit, the block shows an error letter instead of the sum.

Top module: `bcd_sum_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with no press, state_o reads 0 (first operand entry), whatever phase was active before.
- R2: Each rising edge of btn_i moves state_o by one step in the order 0, 1, 2, 0. A button held high for many cycles gives one step only. State code 3 never appears.
- R3: The press that leaves phase 0 captures sw_i as operand A, and the press that leaves phase 1 captures sw_i as operand B. Switch changes during phase 2 do not change the displayed result.
- R4: Switch codes 10 to 15 are not decimal digits. In phase 2, if either operand is such a code, the units output shows the letter E and the tens output is blank.
- R5: In phase 2 with two valid operands and sum s: if s > 9, tens shows 1 and units show s-10. Otherwise tens is blank and units show s.
- R6: In phases 0 and 1 the tens output is blank. The units output shows the live sw_i digit, or E if sw_i is 10 to 15.
- R7: Segment bit i drives segment a..g for i = 0..6 and is active low (0 lights the segment). Blank is 7'h7F. The active-high digit patterns 0 to 9 are 3F,06,5B,4F,66,6D,7D,07,7F,6F, and E is 79; each output is the bitwise inverse of its pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| btn_i | input | 1 | Raw push-button, high when pressed |
| sw_i | input | 4 | Operand switch code |
| seg_tens_no | output | 7 | Tens digit segments, active low, bit 0 = a |
| seg_units_no | output | 7 | Units digit segments, active low, bit 0 = a |
| state_o | output | 2 | Current phase: 0 enter A, 1 enter B, 2 result |

## Verification
A rising edge on btn_i reaches state_o and the operand registers at the second clock edge after it is sampled: one edge for each synchronizer flop, with the edge pulse then acting at the following edge. The segment outputs are combinational from the phase, the operands and the live switches. They settle in the same cycle as a phase change, and a switch change shows at once during entry. Each bench press holds the button for four cycles and releases it for four more. All comparisons are made at falling clock edges after that window, so every result has at least two edges of slack.

// File: rtl/bcd_sum_pkg.sv
// Package: shared widths, phase encoding and segment constants for the
// button-sequenced BCD adder. Assumes 7-segment order bit0=a .. bit6=g.
package bcd_sum_pkg;
    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;
    localparam int MAX_DIGIT = 9;

    typedef enum logic [1:0] {
        PH_ENTER_A = 2'd0,
        PH_ENTER_B = 2'd1,
        PH_RESULT  = 2'd2
    } phase_t;

    localparam logic [SEG_W-1:0] SEG_BLANK_N = {SEG_W{1'b1}};
    localparam logic [SEG_W-1:0] SEG_ERR_N   = ~7'h79;

    // True when a code is a decimal digit
    function automatic logic is_digit(input logic [DIGIT_W-1:0] code);
        return code <= DIGIT_W'(MAX_DIGIT);
    endfunction
endpackage

// File: rtl/btn_edge_sync.sv
// Module: brings a raw button into the clock domain through SYNC_STAGES
// flops and emits a one-cycle pulse on each rising edge. Assumes the button
// is already free of bounce or that bounce pulses are acceptable.
module btn_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic btn_i,
    output logic pulse_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the raw button through the synchronizer and keep the last value
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], btn_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Rising-edge detect on the synchronized level
    assign pulse_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/entry_seq_fsm.sv
// Module: phase sequencer and operand registers. Each step pulse moves one
// phase; the step that leaves an entry phase loads that operand once.
// Assumes step_i is a single-cycle pulse.
module entry_seq_fsm
    import bcd_sum_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               step_i,
    input  logic [DIGIT_W-1:0] sw_i,
    output phase_t             phase_o,
    output logic [DIGIT_W-1:0] op_a_o,
    output logic [DIGIT_W-1:0] op_b_o
);
    phase_t             phase_q;
    logic               a_taken_q, b_taken_q;
    logic               load_a, load_b;

    // One load per operand per pass, gated by the taken flags
    assign load_a = step_i && (phase_q == PH_ENTER_A) && !a_taken_q;
    assign load_b = step_i && (phase_q == PH_ENTER_B) && !b_taken_q;

    // Advance the phase, capture operands, rearm on wrap to entry of A
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q   <= PH_ENTER_A;
            op_a_o    <= '0;
            op_b_o    <= '0;
            a_taken_q <= 1'b0;
            b_taken_q <= 1'b0;
        end else begin
            if (load_a) begin
                op_a_o    <= sw_i;
                a_taken_q <= 1'b1;
            end
            if (load_b) begin
                op_b_o    <= sw_i;
                b_taken_q <= 1'b1;
            end
            if (step_i) begin
                unique case (phase_q)
                    PH_ENTER_A: phase_q <= PH_ENTER_B;
                    PH_ENTER_B: phase_q <= PH_RESULT;
                    default: begin
                        phase_q   <= PH_ENTER_A;
                        a_taken_q <= 1'b0;
                        b_taken_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/bcd_sum_split.sv
// Module: adds two BCD digits and splits the binary sum into tens and units.
// Assumes operands may be any 4-bit code; err_o flags a non-decimal input.
module bcd_sum_split
    import bcd_sum_pkg::*;
(
    input  logic [DIGIT_W-1:0] a_i,
    input  logic [DIGIT_W-1:0] b_i,
    output logic               tens_o,
    output logic [DIGIT_W-1:0] units_o,
    output logic               err_o
);
    localparam int SUM_W = DIGIT_W + 1;
    logic [SUM_W-1:0] sum;

    // Binary add followed by a single decimal correction step
    always_comb begin
        sum    = SUM_W'(a_i) + SUM_W'(b_i);
        err_o  = !is_digit(a_i) || !is_digit(b_i);
        tens_o = sum > SUM_W'(MAX_DIGIT);
        if (tens_o) units_o = DIGIT_W'(sum - SUM_W'(MAX_DIGIT + 1));
        else        units_o = sum[DIGIT_W-1:0];
    end
endmodule

// File: rtl/bcd_seg_enc.sv
// Module: turns a digit code into an active-low seven-segment pattern.
// Blank wins over error; a non-decimal code also shows the error letter.
module bcd_seg_enc
    import bcd_sum_pkg::*;
(
    input  logic [DIGIT_W-1:0] code_i,
    input  logic               blank_i,
    input  logic               err_i,
    output logic [SEG_W-1:0]   seg_no
);
    logic [SEG_W-1:0] lit;

    // Active-high glyph lookup, bit0 = segment a
    always_comb begin
        unique case (code_i)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h79;
        endcase
    end

    // Priority: blank, then error, then digit
    always_comb begin
        if (blank_i)    seg_no = SEG_BLANK_N;
        else if (err_i) seg_no = SEG_ERR_N;
        else            seg_no = ~lit;
    end
endmodule

// File: rtl/bcd_sum_ctrl.sv
// Module: top of the button-sequenced BCD adder. Joins the button pulse
// generator, the phase sequencer, the adder and two segment encoders, and
// selects what each digit shows per phase. Assumes one shared switch bus.
module bcd_sum_ctrl
    import bcd_sum_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               btn_i,
    input  logic [DIGIT_W-1:0] sw_i,
    output logic [SEG_W-1:0]   seg_tens_no,
    output logic [SEG_W-1:0]   seg_units_no,
    output logic [1:0]         state_o
);
    logic               step_pulse;
    phase_t             phase;
    logic [DIGIT_W-1:0] op_a, op_b;
    logic               sum_tens, sum_err;
    logic [DIGIT_W-1:0] sum_units;
    logic [DIGIT_W-1:0] units_code;
    logic               units_err, tens_blank;

    btn_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .btn_i(btn_i), .pulse_o(step_pulse)
    );

    entry_seq_fsm i_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_pulse), .sw_i(sw_i),
        .phase_o(phase), .op_a_o(op_a), .op_b_o(op_b)
    );

    bcd_sum_split i_add (
        .a_i(op_a), .b_i(op_b), .tens_o(sum_tens), .units_o(sum_units),
        .err_o(sum_err)
    );

    // Per-phase choice of the units source and the tens blanking
    always_comb begin
        if (phase == PH_RESULT) begin
            units_code = sum_units;
            units_err  = sum_err;
            tens_blank = sum_err || !sum_tens;
        end else begin
            units_code = sw_i;
            units_err  = !is_digit(sw_i);
            tens_blank = 1'b1;
        end
    end

    bcd_seg_enc i_seg_units (
        .code_i(units_code), .blank_i(1'b0), .err_i(units_err),
        .seg_no(seg_units_no)
    );

    bcd_seg_enc i_seg_tens (
        .code_i(DIGIT_W'(1)), .blank_i(tens_blank), .err_i(1'b0),
        .seg_no(seg_tens_no)
    );

    assign state_o = phase;
endmodule

// File: rtl/bcd_sum_ctrl_chk.sv
// Checker: temporal properties of the BCD adder controller, bound to the top.
module bcd_sum_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       step_pulse,
    input logic [1:0] state_o,
    input logic [3:0] op_a,
    input logic [3:0] op_b,
    input logic [6:0] seg_tens_no,
    input logic [6:0] seg_units_no
);
    // R2
    state_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o != 2'd3);

    // R2
    state_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(state_o) |-> (state_o == (($past(state_o) == 2'd2) ? 2'd0 : $past(state_o) + 2'd1)));

    // R2
    pulse_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_pulse |=> state_o != $past(state_o));

    // R3
    operand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd2 && $past(state_o) == 2'd2) |-> ($stable(op_a) && $stable(op_b)));

    // R4
    err_glyph_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd2 && (op_a > 4'd9 || op_b > 4'd9)) |-> (seg_units_no == 7'h06 && seg_tens_no == 7'h7F));

    // R6
    entry_tens_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o != 2'd2) |-> seg_tens_no == 7'h7F);
endmodule

bind bcd_sum_ctrl bcd_sum_ctrl_chk i_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_pulse(step_pulse), .state_o(state_o),
    .op_a(op_a), .op_b(op_b), .seg_tens_no(seg_tens_no),
    .seg_units_no(seg_units_no)
);

// File: tb/test_bcd_sum_ctrl.sv
// Bench: random and directed passes through the adder sequence.
module test_bcd_sum_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn = 1'b0;
    logic [3:0] sw = 4'd0;
    logic [6:0] seg_t, seg_u;
    logic [1:0] st;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    localparam logic [6:0] BLANK = 7'h7F;

    always #5 clk = ~clk;

    bcd_sum_ctrl i_bcd_sum_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .sw_i(sw),
        .seg_tens_no(seg_t), .seg_units_no(seg_u), .state_o(st)
    );

    // Expected active-low glyph from the R7 table
    function automatic logic [6:0] glyph(input int v);
        logic [6:0] p;
        case (v)
            0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F;
            4: p = 7'h66; 5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07;
            8: p = 7'h7F; 9: p = 7'h6F; default: p = 7'h79;
        endcase
        return ~p;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic press();
        @(negedge clk) btn = 1'b1;
        repeat (4) @(negedge clk);
        btn = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // One full pass with operands a,b; checks entry, result and hold
    task automatic pass(input logic [3:0] a, input logic [3:0] b);
        int s;
        @(negedge clk) sw = a;
        #1;
        check("R6 units live A", 16'(seg_u), 16'(glyph(int'(a))));
        check("R6 tens dark A", 16'(seg_t), 16'(BLANK));
        press();
        check("R2 phase 1", 16'(st), 16'd1);
        sw = b;
        #1;
        check("R6 units live B", 16'(seg_u), 16'(glyph(int'(b))));
        press();
        check("R2 phase 2", 16'(st), 16'd2);
        s = int'(a) + int'(b);
        if (a > 9 || b > 9) begin
            check("R4 err units", 16'(seg_u), 16'(glyph(15)));
            check("R4 err tens", 16'(seg_t), 16'(BLANK));
        end else if (s > 9) begin
            check("R5 units", 16'(seg_u), 16'(glyph(s - 10)));
            check("R5 tens one", 16'(seg_t), 16'(glyph(1)));
        end else begin
            check("R5 units", 16'(seg_u), 16'(glyph(s)));
            check("R5 tens blank", 16'(seg_t), 16'(BLANK));
        end
        begin
            logic [6:0] hu, ht;
            hu = seg_u; ht = seg_t;
            sw = ~sw;
            repeat (2) @(negedge clk);
            check("R3 units hold", 16'(seg_u), 16'(hu));
            check("R3 tens hold", 16'(seg_t), 16'(ht));
        end
        press();
        check("R2 wrap to 0", 16'(st), 16'd0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 reset phase", 16'(st), 16'd0);
        check("R1 reset tens", 16'(seg_t), 16'(BLANK));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle phase", 16'(st), 16'd0);
        check("R7 zero glyph", 16'(seg_u), 16'h40);
        // Held button: one step only
        btn = 1'b1;
        repeat (20) @(negedge clk);
        check("R2 held once", 16'(st), 16'd1);
        btn = 1'b0;
        repeat (4) @(negedge clk);
        // Reset mid-pass
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset mid-pass", 16'(st), 16'd0);
        // Entry of an invalid live code
        sw = 4'd12;
        #1;
        check("R6 live E", 16'(seg_u), 16'(glyph(15)));
        // Directed corners
        pass(4'd0, 4'd0);
        pass(4'd9, 4'd9);
        pass(4'd4, 4'd5);
        pass(4'd5, 4'd5);
        pass(4'd10, 4'd3);
        pass(4'd2, 4'd15);
        pass(4'd7, 4'd8);
        for (int i = 0; i < 60; i++) begin
            logic [3:0] ra, rb;
            ra = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 10);
            rb = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 10);
            pass(ra, rb);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hang counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule